// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a freshly powered SDRAM device from reset to a state where a normal memory controller can take over. It is a small hardware state machine that walks a fixed list of steps. The list depends on the memory family, which is chosen at elaboration: single data rate, double data rate, low-power double data rate, or second-generation double data rate. Each step either raises the device control pins or places one command on a phase-0 command port for exactly one cycle. After each step the block counts a programmed number of idle cycles before it starts the next one.

The block works out the mode register word from the CAS latency and the burst length. The burst length follows from the number of PHY phases. The block first loads that word with the DLL-reset bit set. It then precharges, refreshes twice and loads the word again without the DLL-reset bit. Before the DLL-reset load it writes zeroed extended mode registers in a family-specific order. The second-generation family also writes an off-chip-driver calibration default and then an exit. When the last step and its idle time are over, `init_done` rises and stays high until reset.

The command port carries no data and has no back-pressure. A command is valid for the single cycle in which `cmd_issue` is high, and the PHY must accept it in that cycle. All command flags are low in every other cycle, which is a NOP. An unsupported memory family selector, a phase count that is not a power of two, or an address narrower than 11 bits stops elaboration.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, every output is low. On the first clock edge after reset is released, `ctl_cke`, `ctl_odt` and `ctl_reset_n` go high together with no command. They stay high from then on.
- R2: A command is shown with `cmd_issue` high for one cycle, flags as {cs,ras,cas,we}: precharge-all 1101, mode register load 1111, auto refresh 1110. Whenever `cmd_issue` is low all four flags are 0.
- R3: The first command strobe comes 1 + CKE_WAIT cycles after the cycle in which the control pins rose. In general, each command follows the previous step by 1 + that step's wait.
- R4: Precharge-all uses address 0x400 and bank 0 and has a wait of 0, so the next command appears in the very next cycle.
- R5: The mode word is log2(BL) + (CAS_LAT << 4), with BL = N_PHASES for single data rate and 2*N_PHASES for the double-rate families. The second-generation family adds 2 << 9 for write recovery. All mode register loads go to bank 0.
- R6: The mode register is loaded with bit 8 set and then waits LMR_WAIT. Then come a precharge-all, two auto refreshes (address 0, bank 0, each followed by AREF_WAIT) and a second load without bit 8, also followed by LMR_WAIT.
- R7: Before the DLL-reset load, one zero extended register write is made, to bank 1 for the double-data-rate family and to bank 2 for the low-power family. The single-data-rate family issues no command to a non-zero bank.
- R8: The second-generation family writes zero to banks 3, 2 and 1, in that order, before the DLL-reset load, each with a wait of 0.
- R9: After its final mode load, the second-generation family writes 0x380 to bank 1 and then 0 to bank 1, each with a wait of 0.
- R10: `init_done` rises 1 + (last step's wait) cycles after the final command. It stays high until reset, and no command is issued while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dfi_address | output | ADDR_W | Command address, phase 0 |
| dfi_bank | output | BA_W | Command bank address, phase 0 |
| dfi_cs | output | 1 | Chip-select flag, active high |
| dfi_ras | output | 1 | Row-strobe flag, active high |
| dfi_cas | output | 1 | Column-strobe flag, active high |
| dfi_we | output | 1 | Write-enable flag, active high |
| cmd_issue | output | 1 | One-cycle strobe marking a valid command |
| ctl_cke | output | 1 | Clock enable to the device |
| ctl_odt | output | 1 | On-die termination enable |
| ctl_reset_n | output | 1 | Device reset release, high = released |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The hardest behaviour to reach is the family-specific middle and tail of the list: the descending bank order of the extended writes and the calibration default/exit pair. A single build only ever shows one family. The bench therefore builds all four families side by side, with short waits and different phase counts and CAS latencies. It compares every strobe against a step list derived in the bench and checks each gap against the wait of the previous step. The back-to-back commands after a zero wait are checked the same way.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int MEM_SDR   = 0;
  localparam int MEM_DDR   = 1;
  localparam int MEM_LPDDR = 2;
  localparam int MEM_DDR2  = 3;

  localparam int MAX_STEPS = 12;

  typedef enum logic [1:0] {
    OP_CTRL = 2'd0,
    OP_PREA = 2'd1,
    OP_LMR  = 2'd2,
    OP_AREF = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    WT_NONE = 2'd0,
    WT_CKE  = 2'd1,
    WT_LMR  = 2'd2,
    WT_AREF = 2'd3
  } wait_e;

  typedef struct packed {
    op_e         op;
    logic [15:0] addr;
    logic [2:0]  bank;
    wait_e       wsel;
  } step_t;

  // number of extended register writes ahead of the DLL-reset load
  function automatic int ext_count(int mt);
    if (mt == MEM_SDR)  return 0;
    if (mt == MEM_DDR2) return 3;
    return 1;
  endfunction

  function automatic int step_count(int mt);
    return 7 + ext_count(mt) + ((mt == MEM_DDR2) ? 2 : 0);
  endfunction

  function automatic int burst_len(int mt, int phases);
    return (mt == MEM_SDR) ? phases : 2 * phases;
  endfunction

  function automatic logic [15:0] mode_word(int mt, int cl, int phases);
    int bl;
    int lg;
    logic [15:0] w;
    bl = burst_len(mt, phases);
    lg = 0;
    for (int b = 0; b < 16; b++) begin
      if ((1 << b) == bl) lg = b;
    end
    w = 16'(lg) + 16'(cl << 4);
    if (mt == MEM_DDR2) w = w + 16'(2 << 9);
    return w;
  endfunction

  function automatic step_t step_lookup(int mt, int idx, logic [15:0] mr);
    step_t s;
    int    ne;
    int    k;
    ne = ext_count(mt);
    s.op   = OP_CTRL;
    s.addr = 16'h0000;
    s.bank = 3'd0;
    s.wsel = WT_NONE;
    if (idx == 0) begin
      s.wsel = WT_CKE;
    end else if (idx == 1) begin
      s.op   = OP_PREA;
      s.addr = 16'h0400;
    end else if (idx < 2 + ne) begin
      s.op = OP_LMR;
      if (mt == MEM_LPDDR)    s.bank = 3'd2;
      else if (mt == MEM_DDR) s.bank = 3'd1;
      else                    s.bank = 3'(3 - (idx - 2));
    end else begin
      k = idx - 2 - ne;
      case (k)
        0: begin
          s.op   = OP_LMR;
          s.addr = mr | 16'h0100;
          s.wsel = WT_LMR;
        end
        1: begin
          s.op   = OP_PREA;
          s.addr = 16'h0400;
        end
        2, 3: begin
          s.op   = OP_AREF;
          s.wsel = WT_AREF;
        end
        4: begin
          s.op   = OP_LMR;
          s.addr = mr;
          s.wsel = WT_LMR;
        end
        5: begin
          s.op   = OP_LMR;
          s.addr = 16'h0380;
          s.bank = 3'd1;
        end
        default: begin
          s.op   = OP_LMR;
          s.bank = 3'd1;
        end
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/sdram_init_rom.sv
module sdram_init_rom
  import sdram_init_pkg::*;
#(
  parameter int MEM_TYPE = MEM_DDR2,
  parameter int CAS_LAT  = 3,
  parameter int N_PHASES = 2,
  parameter int ADDR_W   = 14,
  parameter int IDX_W    = 4
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            step,
  output logic             at_end
);

  localparam int          NSTEPS  = step_count(MEM_TYPE);
  localparam logic [15:0] MR_WORD = mode_word(MEM_TYPE, CAS_LAT, N_PHASES);

  generate
    if (MEM_TYPE < MEM_SDR || MEM_TYPE > MEM_DDR2) begin : g_bad_type
      $error("sdram_init_rom: unsupported memory family selector");
    end
    if (N_PHASES < 1 || (N_PHASES & (N_PHASES - 1)) != 0) begin : g_bad_phases
      $error("sdram_init_rom: phase count must be a power of two");
    end
    if (ADDR_W < 11 || ADDR_W > 16) begin : g_bad_addr
      $error("sdram_init_rom: address width must lie in 11..16");
    end
  endgenerate

  always_comb begin
    step   = step_lookup(MEM_TYPE, int'(idx), MR_WORD);
    at_end = (int'(idx) == NSTEPS);
  end

endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_issue.sv
module sdram_init_issue
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  step_t             step,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   bank_o,
  output logic              cs_o,
  output logic              ras_o,
  output logic              cas_o,
  output logic              we_o,
  output logic              strobe_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic              rstn_o
);

  logic cmd_fire;
  logic ctl_fire;

  assign cmd_fire = fire && (step.op != OP_CTRL);
  assign ctl_fire = fire && (step.op == OP_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o   <= '0;
      bank_o   <= '0;
      cs_o     <= 1'b0;
      ras_o    <= 1'b0;
      cas_o    <= 1'b0;
      we_o     <= 1'b0;
      strobe_o <= 1'b0;
    end else if (cmd_fire) begin
      addr_o   <= step.addr[ADDR_W-1:0];
      bank_o   <= BA_W'(step.bank);
      strobe_o <= 1'b1;
      cs_o     <= 1'b1;
      ras_o    <= 1'b1;
      cas_o    <= (step.op == OP_LMR) || (step.op == OP_AREF);
      we_o     <= (step.op == OP_LMR) || (step.op == OP_PREA);
    end else begin
      addr_o   <= '0;
      bank_o   <= '0;
      strobe_o <= 1'b0;
      cs_o     <= 1'b0;
      ras_o    <= 1'b0;
      cas_o    <= 1'b0;
      we_o     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_o  <= 1'b0;
      odt_o  <= 1'b0;
      rstn_o <= 1'b0;
    end else if (ctl_fire) begin
      cke_o  <= 1'b1;
      odt_o  <= 1'b1;
      rstn_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int MEM_TYPE  = MEM_DDR2,
  parameter int CAS_LAT   = 3,
  parameter int N_PHASES  = 2,
  parameter int ADDR_W    = 14,
  parameter int BA_W      = 3,
  parameter int CKE_WAIT  = 20000,
  parameter int LMR_WAIT  = 200,
  parameter int AREF_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] dfi_address,
  output logic [BA_W-1:0]   dfi_bank,
  output logic              dfi_cs,
  output logic              dfi_ras,
  output logic              dfi_cas,
  output logic              dfi_we,
  output logic              cmd_issue,
  output logic              ctl_cke,
  output logic              ctl_odt,
  output logic              ctl_reset_n,
  output logic              init_done
);

  localparam int IDX_W    = $clog2(MAX_STEPS + 1);
  localparam int MAX_WAIT = (CKE_WAIT > LMR_WAIT)
                          ? ((CKE_WAIT > AREF_WAIT) ? CKE_WAIT : AREF_WAIT)
                          : ((LMR_WAIT > AREF_WAIT) ? LMR_WAIT : AREF_WAIT);
  localparam int CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  step_t            cur_step;
  logic             at_end;
  logic             expired;
  logic             go;
  logic             fire;
  logic [CNT_W-1:0] wait_val;

  sdram_init_rom #(
    .MEM_TYPE (MEM_TYPE),
    .CAS_LAT  (CAS_LAT),
    .N_PHASES (N_PHASES),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_rom (
    .idx    (idx_q),
    .step   (cur_step),
    .at_end (at_end)
  );

  assign go   = expired && !done_q;
  assign fire = go && !at_end;

  always_comb begin
    unique case (cur_step.wsel)
      WT_CKE:  wait_val = CNT_W'(CKE_WAIT);
      WT_LMR:  wait_val = CNT_W'(LMR_WAIT);
      WT_AREF: wait_val = CNT_W'(AREF_WAIT);
      default: wait_val = '0;
    endcase
  end

  sdram_init_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire),
    .load_val (wait_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (go) begin
      if (at_end) done_q <= 1'b1;
      else        idx_q  <= idx_q + 1'b1;
    end
  end

  sdram_init_issue #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .step     (cur_step),
    .addr_o   (dfi_address),
    .bank_o   (dfi_bank),
    .cs_o     (dfi_cs),
    .ras_o    (dfi_ras),
    .cas_o    (dfi_cas),
    .we_o     (dfi_we),
    .strobe_o (cmd_issue),
    .cke_o    (ctl_cke),
    .odt_o    (ctl_odt),
    .rstn_o   (ctl_reset_n)
  );

  assign init_done = done_q;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] dfi_address,
  input logic [BA_W-1:0]   dfi_bank,
  input logic              dfi_cs,
  input logic              dfi_ras,
  input logic              dfi_cas,
  input logic              dfi_we,
  input logic              cmd_issue,
  input logic              ctl_cke,
  input logic              ctl_odt,
  input logic              ctl_reset_n,
  input logic              init_done
);

  p_nop_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_issue |-> !(dfi_cs || dfi_ras || dfi_cas || dfi_we));

  p_cs_on_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> (dfi_cs && dfi_ras));

  p_cmd_after_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> (ctl_cke && ctl_odt && ctl_reset_n));

  p_prea_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && dfi_we && !dfi_cas) |-> (dfi_address == ADDR_W'(16'h0400) && dfi_bank == '0));

  p_aref_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && dfi_cas && !dfi_we) |-> (dfi_address == '0 && dfi_bank == '0));

  p_ctl_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cke |=> (ctl_cke && ctl_odt && ctl_reset_n));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_issue);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dfi_address (dfi_address),
  .dfi_bank    (dfi_bank),
  .dfi_cs      (dfi_cs),
  .dfi_ras     (dfi_ras),
  .dfi_cas     (dfi_cas),
  .dfi_we      (dfi_we),
  .cmd_issue   (cmd_issue),
  .ctl_cke     (ctl_cke),
  .ctl_odt     (ctl_odt),
  .ctl_reset_n (ctl_reset_n),
  .init_done   (init_done)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

  localparam int CW = 20;
  localparam int MW = 7;
  localparam int RW = 3;
  localparam int AW = 14;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] ad_v [NI];
  logic [2:0]    ba_v [NI];
  logic [NI-1:0] cs_v, ras_v, cas_v, we_v, iss_v, cke_v, odt_v, rn_v, dn_v;

  sdram_init_seq #(.MEM_TYPE(0), .CAS_LAT(2), .N_PHASES(2), .ADDR_W(AW), .BA_W(3),
    .CKE_WAIT(CW), .LMR_WAIT(MW), .AREF_WAIT(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .dfi_address(ad_v[0]), .dfi_bank(ba_v[0]),
    .dfi_cs(cs_v[0]), .dfi_ras(ras_v[0]), .dfi_cas(cas_v[0]), .dfi_we(we_v[0]),
    .cmd_issue(iss_v[0]), .ctl_cke(cke_v[0]), .ctl_odt(odt_v[0]),
    .ctl_reset_n(rn_v[0]), .init_done(dn_v[0]));

  sdram_init_seq #(.MEM_TYPE(1), .CAS_LAT(3), .N_PHASES(2), .ADDR_W(AW), .BA_W(3),
    .CKE_WAIT(CW), .LMR_WAIT(MW), .AREF_WAIT(RW)) u1 (
    .clk(clk), .rst_n(rst_n), .dfi_address(ad_v[1]), .dfi_bank(ba_v[1]),
    .dfi_cs(cs_v[1]), .dfi_ras(ras_v[1]), .dfi_cas(cas_v[1]), .dfi_we(we_v[1]),
    .cmd_issue(iss_v[1]), .ctl_cke(cke_v[1]), .ctl_odt(odt_v[1]),
    .ctl_reset_n(rn_v[1]), .init_done(dn_v[1]));

  sdram_init_seq #(.MEM_TYPE(2), .CAS_LAT(3), .N_PHASES(4), .ADDR_W(AW), .BA_W(3),
    .CKE_WAIT(CW), .LMR_WAIT(MW), .AREF_WAIT(RW)) u2 (
    .clk(clk), .rst_n(rst_n), .dfi_address(ad_v[2]), .dfi_bank(ba_v[2]),
    .dfi_cs(cs_v[2]), .dfi_ras(ras_v[2]), .dfi_cas(cas_v[2]), .dfi_we(we_v[2]),
    .cmd_issue(iss_v[2]), .ctl_cke(cke_v[2]), .ctl_odt(odt_v[2]),
    .ctl_reset_n(rn_v[2]), .init_done(dn_v[2]));

  sdram_init_seq #(.MEM_TYPE(3), .CAS_LAT(4), .N_PHASES(2), .ADDR_W(AW), .BA_W(3),
    .CKE_WAIT(CW), .LMR_WAIT(MW), .AREF_WAIT(RW)) u3 (
    .clk(clk), .rst_n(rst_n), .dfi_address(ad_v[3]), .dfi_bank(ba_v[3]),
    .dfi_cs(cs_v[3]), .dfi_ras(ras_v[3]), .dfi_cas(cas_v[3]), .dfi_we(we_v[3]),
    .cmd_issue(iss_v[3]), .ctl_cke(cke_v[3]), .ctl_odt(odt_v[3]),
    .ctl_reset_n(rn_v[3]), .init_done(dn_v[3]));

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected step lists: kind 0 = pins, 1 = precharge-all, 2 = mode load, 3 = refresh
  int ek [NI][16];
  int ea [NI][16];
  int eb [NI][16];
  int ew [NI][16];
  int en [NI];
  int mtype [NI] = '{0, 1, 2, 3};
  int phs   [NI] = '{2, 2, 4, 2};
  int cls   [NI] = '{2, 3, 3, 4};

  task automatic push(input int i, input int k, input int a, input int b, input int w);
    ek[i][en[i]] = k;
    ea[i][en[i]] = a;
    eb[i][en[i]] = b;
    ew[i][en[i]] = w;
    en[i]++;
  endtask

  task automatic build(input int i);
    int bl;
    int lg;
    int mr;
    bl = (mtype[i] == 0) ? phs[i] : 2 * phs[i];
    lg = 0;
    while ((1 << lg) < bl) lg++;
    mr = lg + cls[i] * 16 + ((mtype[i] == 3) ? 1024 : 0);
    en[i] = 0;
    push(i, 0, 0, 0, CW);
    push(i, 1, 'h400, 0, 0);
    if (mtype[i] == 1) push(i, 2, 0, 1, 0);
    if (mtype[i] == 2) push(i, 2, 0, 2, 0);
    if (mtype[i] == 3) begin
      push(i, 2, 0, 3, 0);
      push(i, 2, 0, 2, 0);
      push(i, 2, 0, 1, 0);
    end
    push(i, 2, mr + 256, 0, MW);
    push(i, 1, 'h400, 0, 0);
    push(i, 3, 0, 0, RW);
    push(i, 3, 0, 0, RW);
    push(i, 2, mr, 0, MW);
    if (mtype[i] == 3) begin
      push(i, 2, 'h380, 1, 0);
      push(i, 2, 0, 1, 0);
    end
  endtask

  function automatic int flags_of(input int k);
    if (k == 1) return 'b1101;
    if (k == 2) return 'b1111;
    return 'b1110;
  endfunction

  function automatic string addr_req(input int i, input int k, input int b);
    if (k == 1) return "R4";
    if (k == 3) return "R6";
    if (b == 0) return "R5";
    return (mtype[i] == 3) ? "R8 R9" : "R7";
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int ev [NI];
  int last_c [NI];
  bit cke_p [NI];
  bit dn_p [NI];
  int nop_bad [NI];
  int post_iss [NI];
  int nz_bank [NI];
  bit running = 1'b0;

  always @(negedge clk) begin
    if (running) begin
      for (int i = 0; i < NI; i++) begin
        if (cke_v[i] && !cke_p[i]) begin
          check(ev[i] == 0 && cyc == 1, "R1 pins rise", cyc, 1);
          check(odt_v[i] && rn_v[i] && !iss_v[i], "R1 odt/reset_n", {odt_v[i], rn_v[i], iss_v[i]}, 3'b110);
          last_c[i] = cyc;
          ev[i] = 1;
        end
        if (iss_v[i]) begin
          if (dn_v[i]) post_iss[i]++;
          if (ba_v[i] != 0) nz_bank[i]++;
          if (ev[i] >= en[i] || ev[i] == 0) begin
            check(1'b0, "R10 extra command", ev[i], en[i]);
          end else begin
            check({cs_v[i], ras_v[i], cas_v[i], we_v[i]} == 4'(flags_of(ek[i][ev[i]])),
                  "R2 flags", {cs_v[i], ras_v[i], cas_v[i], we_v[i]}, flags_of(ek[i][ev[i]]));
            check(int'(ad_v[i]) == ea[i][ev[i]], addr_req(i, ek[i][ev[i]], eb[i][ev[i]]),
                  int'(ad_v[i]), ea[i][ev[i]]);
            check(int'(ba_v[i]) == eb[i][ev[i]], addr_req(i, ek[i][ev[i]], eb[i][ev[i]]),
                  int'(ba_v[i]), eb[i][ev[i]]);
            check(cyc - last_c[i] == 1 + ew[i][ev[i]-1], (ev[i] == 1) ? "R3 gap" : "R6 gap",
                  cyc - last_c[i], 1 + ew[i][ev[i]-1]);
            last_c[i] = cyc;
            ev[i]++;
          end
        end else if (cs_v[i] || ras_v[i] || cas_v[i] || we_v[i]) begin
          nop_bad[i]++;
        end
        if (dn_v[i] && !dn_p[i]) begin
          check(ev[i] == en[i], "R10 steps before done", ev[i], en[i]);
          check(cyc - last_c[i] == 1 + ew[i][en[i]-1], "R10 done gap",
                cyc - last_c[i], 1 + ew[i][en[i]-1]);
        end
        cke_p[i] = cke_v[i];
        dn_p[i]  = dn_v[i];
      end
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) begin
      build(i);
      ev[i] = 0; last_c[i] = 0; cke_p[i] = 0; dn_p[i] = 0;
      nop_bad[i] = 0; post_iss[i] = 0; nz_bank[i] = 0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check({ad_v[i], ba_v[i], cs_v[i], ras_v[i], cas_v[i], we_v[i], iss_v[i],
             cke_v[i], odt_v[i], rn_v[i], dn_v[i]} == '0, "R1 reset state", 1, 0);
    end
    rst_n = 1'b1;
    running = 1'b1;
    begin
      int w;
      w = 0;
      while (dn_v != '1 && w < 3000) begin
        @(negedge clk);
        w++;
      end
      if (dn_v != '1) check(1'b0, "R10 watchdog", int'(dn_v), 'hf);
    end
    repeat (25) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check(dn_v[i] == 1'b1, "R10 done held", dn_v[i], 1);
      check(post_iss[i] == 0, "R10 quiet after done", post_iss[i], 0);
      check(nop_bad[i] == 0, "R2 nop between commands", nop_bad[i], 0);
      check(cke_v[i] && odt_v[i] && rn_v[i], "R1 pins held", {cke_v[i], odt_v[i], rn_v[i]}, 7);
    end
    check(nz_bank[0] == 0, "R7 single-rate family banks", nz_bank[0], 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule